// File: doc/BRIEF.md
# Operand Combiner with Single-Step Shifter

This unit is the arithmetic stage of a small microcoded processor. It takes two operand words, one from the A side and one from the B side, and combines them under a 2-bit function code. The result then goes through a shifter with its own 2-bit control, which can leave the word as it is or move it by one bit. The shifted word drives the result bus back to the register file.

Two status flags describe the combined word before it is shifted. The negative flag copies its top bit, and the zero flag is set when every bit of it is clear. The sequencer uses these flags for conditional branching. The unit holds no state and has no clock. Every output is a pure function of the present inputs.

There are no states or transitions. Operand selection, register storage, sequencing and clocking all belong to the surrounding datapath.

Top module: `opshift_unit`

## Requirements
- R1: Function code 2'b00 gives the sum of the A and B operands modulo 2^16, with no carry output.
- R2: Function code 2'b01 gives the bitwise AND of the A and B operands.
- R3: Function code 2'b10 gives the bitwise complement of the A operand, and the B operand has no effect.
- R4: Function code 2'b11 passes the A operand through unchanged, and the B operand has no effect.
- R5: Shift code 2'b00 and shift code 2'b11 both leave the combined word unshifted on the result bus.
- R6: Shift code 2'b01 moves the combined word right by one bit. Bit 15 of the result is filled with zero.
- R7: Shift code 2'b10 moves the combined word left by one bit. Bit 0 of the result is filled with zero.
- R8: The negative flag equals bit 15 of the combined word before shifting, whatever the shift code.
- R9: The zero flag is high exactly when all 16 bits of the combined word before shifting are zero, whatever the shift code.
- R10: The outputs follow an input change with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_opnd | input | 16 | A-side operand, already selected upstream |
| b_opnd | input | 16 | B-side operand |
| fn_sel | input | 2 | Combining function: 00 add, 01 AND, 10 complement A, 11 pass A |
| sh_sel | input | 2 | Shift: 00 none, 01 right by one, 10 left by one, 11 none |
| c_word | output | 16 | Shifted result driven to the result bus |
| neg_flag | output | 1 | Top bit of the combined word before shifting |
| zero_flag | output | 1 | High when the combined word before shifting is all zero |

## Verification
Each result is due in the same cycle as its stimulus, because no register lies between the inputs and any output. The bench changes the inputs just after a falling clock edge. It reads the outputs a quarter period later, before the next rising edge, so every check sees only the settled combinational value. One directed test changes the inputs and reads the outputs after a short delay with no clock edge in between, which confirms that nothing waits on a clock.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_AND  = 2'b01,
        FN_NOTA = 2'b10,
        FN_PASS = 2'b11
    } fn_code_t;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_IDLE  = 2'b11
    } sh_code_t;

endpackage

// File: rtl/opshift_combiner.sv
module opshift_combiner
    import opshift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       fn_in,
    output logic [WIDTH-1:0] res_out
);

    fn_code_t fn_code;

    always_comb begin
        fn_code = fn_code_t'(fn_in);
        unique case (fn_code)
            FN_ADD:  res_out = a_in + b_in;
            FN_AND:  res_out = a_in & b_in;
            FN_NOTA: res_out = ~a_in;
            FN_PASS: res_out = a_in;
            default: res_out = a_in;
        endcase
    end

endmodule

// File: rtl/opshift_shifter.sv
module opshift_shifter
    import opshift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic [1:0]       sh_in,
    output logic [WIDTH-1:0] word_out
);

    sh_code_t sh_code;

    always_comb begin
        sh_code = sh_code_t'(sh_in);
        unique case (sh_code)
            SH_RIGHT: word_out = {1'b0, word_in[WIDTH-1:1]};
            SH_LEFT:  word_out = {word_in[WIDTH-2:0], 1'b0};
            SH_NONE:  word_out = word_in;
            SH_IDLE:  word_out = word_in;
            default:  word_out = word_in;
        endcase
    end

endmodule

// File: rtl/opshift_flags.sv
module opshift_flags #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word_in,
    output logic             neg_out,
    output logic             zero_out
);

    localparam int TOP = WIDTH - 1;

    always_comb begin
        neg_out  = word_in[TOP];
        zero_out = ~(|word_in);
    end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_opnd,
    input  logic [WIDTH-1:0] b_opnd,
    input  logic [1:0]       fn_sel,
    input  logic [1:0]       sh_sel,
    output logic [WIDTH-1:0] c_word,
    output logic             neg_flag,
    output logic             zero_flag
);

    localparam int TOP = WIDTH - 1;
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] comb_word;

    opshift_combiner #(.WIDTH(WIDTH)) u_comb (
        .a_in    (a_opnd),
        .b_in    (b_opnd),
        .fn_in   (fn_sel),
        .res_out (comb_word)
    );

    opshift_shifter #(.WIDTH(WIDTH)) u_shift (
        .word_in  (comb_word),
        .sh_in    (sh_sel),
        .word_out (c_word)
    );

    opshift_flags #(.WIDTH(WIDTH)) u_flags (
        .word_in  (comb_word),
        .neg_out  (neg_flag),
        .zero_out (zero_flag)
    );

    // Checks across the three sub-units; the block has no clock, so these are immediate.
    always_comb begin
        if (!$isunknown({a_opnd, b_opnd, fn_sel, sh_sel})) begin
            a_r2_and_subset: assert (fn_sel != FN_AND || (comb_word & ~b_opnd & ~a_opnd) == '0 && (comb_word & ~b_opnd) == '0)
                else $error("R2: AND result has bits outside B");
            a_r3_complement: assert (fn_sel != FN_NOTA || (comb_word ^ a_opnd) == ALL_ONES)
                else $error("R3: complement result wrong");
            a_r4_passthru: assert (fn_sel != FN_PASS || comb_word == a_opnd)
                else $error("R4: pass result differs from A");
            a_r5_no_shift: assert (!(sh_sel == SH_NONE || sh_sel == SH_IDLE) || c_word == comb_word)
                else $error("R5: unshifted output differs");
            a_r6_right_fill: assert (sh_sel != SH_RIGHT || (c_word[TOP] == 1'b0 && c_word[TOP-1:0] == comb_word[TOP:1]))
                else $error("R6: right shift wrong");
            a_r7_left_fill: assert (sh_sel != SH_LEFT || (c_word[0] == 1'b0 && c_word[TOP:1] == comb_word[TOP-1:0]))
                else $error("R7: left shift wrong");
            a_r8_neg_preshift: assert (neg_flag == comb_word[TOP])
                else $error("R8: negative flag mismatch");
            a_r9_zero_preshift: assert (zero_flag == (comb_word == '0))
                else $error("R9: zero flag mismatch");
        end
    end

endmodule

// File: tb/opshift_unit_bench.sv
module opshift_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic        clk = 1'b0;
    logic [15:0] a_opnd = '0;
    logic [15:0] b_opnd = '0;
    logic [1:0]  fn_sel = '0;
    logic [1:0]  sh_sel = '0;
    logic [15:0] c_word;
    logic        neg_flag;
    logic        zero_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opshift_unit u_opshift_unit (
        .a_opnd    (a_opnd),
        .b_opnd    (b_opnd),
        .fn_sel    (fn_sel),
        .sh_sel    (sh_sel),
        .c_word    (c_word),
        .neg_flag  (neg_flag),
        .zero_flag (zero_flag)
    );

    // Entry layout: {a, b, fn, sh, expected c, expected n, expected z}
    localparam logic [53:0] VECS [NVEC] = '{
        {16'h0001, 16'h0002, 2'b00, 2'b00, 16'h0003, 1'b0, 1'b0}, // R1
        {16'hFFFF, 16'h0001, 2'b00, 2'b00, 16'h0000, 1'b0, 1'b1}, // R1 wrap, R9
        {16'h8000, 16'h8000, 2'b00, 2'b00, 16'h0000, 1'b0, 1'b1}, // R1 wrap
        {16'h7FFF, 16'h0001, 2'b00, 2'b00, 16'h8000, 1'b1, 1'b0}, // R1, R8
        {16'hF0F0, 16'h3C3C, 2'b01, 2'b00, 16'h3030, 1'b0, 1'b0}, // R2
        {16'h00FF, 16'h1234, 2'b10, 2'b00, 16'hFF00, 1'b1, 1'b0}, // R3
        {16'h1234, 16'hFFFF, 2'b11, 2'b00, 16'h1234, 1'b0, 1'b0}, // R4
        {16'h1234, 16'h0000, 2'b11, 2'b01, 16'h091A, 1'b0, 1'b0}, // R6
        {16'h8001, 16'h0000, 2'b11, 2'b10, 16'h0002, 1'b1, 1'b0}, // R7, R8
        {16'h8001, 16'h0000, 2'b11, 2'b01, 16'h4000, 1'b1, 1'b0}, // R6, R8
        {16'h1234, 16'h5555, 2'b11, 2'b11, 16'h1234, 1'b0, 1'b0}, // R5
        {16'h8000, 16'h0000, 2'b11, 2'b10, 16'h0000, 1'b1, 1'b0}, // R7, R9
        {16'h0001, 16'h0000, 2'b11, 2'b01, 16'h0000, 1'b0, 1'b0}, // R6, R9
        {16'hAAAA, 16'h5555, 2'b01, 2'b10, 16'h0000, 1'b0, 1'b1}, // R2, R9
        {16'hFFFF, 16'h0000, 2'b10, 2'b01, 16'h0000, 1'b0, 1'b1}, // R3, R9
        {16'h0000, 16'h9999, 2'b10, 2'b10, 16'hFFFE, 1'b1, 1'b0}  // R3, R7
    };

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got c=%h n=%b z=%b expected c=%h n=%b z=%b",
                     req, got[17:2], got[1], got[0], exp[17:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic [1:0] fn, input logic [1:0] sh);
        @(negedge clk);
        a_opnd = a;
        b_opnd = b;
        fn_sel = fn;
        sh_sel = sh;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        // Initial state: all-zero inputs mean add 0+0, no shift.
        #(CLK_PERIOD/4);
        check("R1 initial", {c_word, neg_flag, zero_flag}, {16'h0000, 1'b0, 1'b1});

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][53:38], VECS[i][37:22], VECS[i][21:20], VECS[i][19:18]);
            check($sformatf("R1-table entry %0d", i), {c_word, neg_flag, zero_flag}, VECS[i][17:0]);
        end

        // R3 / R4: B has no effect under complement and pass
        apply(16'h0F0F, 16'h0000, 2'b10, 2'b00);
        check("R3 b ignored", {c_word, neg_flag, zero_flag}, {16'hF0F0, 1'b1, 1'b0});
        apply(16'h0F0F, 16'hFFFF, 2'b10, 2'b00);
        check("R3 b ignored", {c_word, neg_flag, zero_flag}, {16'hF0F0, 1'b1, 1'b0});
        apply(16'h0F0F, 16'hABCD, 2'b11, 2'b00);
        check("R4 b ignored", {c_word, neg_flag, zero_flag}, {16'h0F0F, 1'b0, 1'b0});

        // R5: shift code 11 behaves as no shift
        apply(16'hC003, 16'h0000, 2'b11, 2'b11);
        check("R5 code 11", {c_word, neg_flag, zero_flag}, {16'hC003, 1'b1, 1'b0});

        // R8 / R9: flags taken before shift when shift loses the only set bit
        apply(16'h4000, 16'h4000, 2'b00, 2'b10);
        check("R8 R9 preshift", {c_word, neg_flag, zero_flag}, {16'h0000, 1'b1, 1'b0});

        // R10: change inputs and read with no clock edge in between
        @(negedge clk);
        a_opnd = 16'h0010;
        b_opnd = 16'h0020;
        fn_sel = 2'b00;
        sh_sel = 2'b10;
        #1;
        check("R10 no clock", {c_word, neg_flag, zero_flag}, {16'h0060, 1'b0, 1'b0});
        a_opnd = 16'hFFF0;
        #1;
        check("R10 no clock", {c_word, neg_flag, zero_flag}, {16'h0020, 1'b0, 1'b0});

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule